// File: doc/BRIEF.md
# Indexed Postbyte Effective-Address Unit

This unit handles the indexed addressing byte that follows an opcode in a 16-bit-address, 8-bit-data processor. The sequencer gives it the postbyte, the next two instruction bytes, the address of the postbyte and the current index and accumulator values. One clock after a `start` pulse, the unit returns a registered result. The result holds the effective address, the number of bytes the postbyte and its extension use, and whether the address still has to be dereferenced. For auto-modify modes it also gives the updated value for the base register, together with a write enable. A separate flag marks postbyte forms that a memory-to-memory move may not use.

The postbyte splits into three groups. With bit 5 clear, it carries a small signed constant. With bit 5 set and a top pair other than `11`, it increments or decrements a register by 1 to 8, either before or after the access. When the top three bits are `111`, the group holds the 9-bit and 16-bit constant forms, the accumulator-offset forms and two indirect forms. The unit does not fetch the pointer for indirect forms and does not write the register file; both tasks belong to the surrounding pipeline.

Top module: `idx_agen`

## Requirements
- R1: `valid` is high in exactly the cycle after a cycle with `start` high. All result outputs change only on a `start` cycle and otherwise hold their values.
- R2: If postbyte bit 5 is 0, `ea` = base + sign-extended bits 4:0 and `len` = 1. Bits 7:6 pick the base: 00 X, 01 Y, 10 SP, 11 PC.
- R3: If bit 5 is 1 and bits 7:6 are not 11, the mode is auto-modify. Bits 3:0 are read as a signed nibble. A negative nibble moves the register down by its magnitude (1 to 8). A nibble v of 0 to 7 moves it up by v+1. The unit sets `wb_en` = 1, `wb_sel` = bits 7:6 and `wb_val` = base + step, with `len` = 1.
- R4: In auto-modify, bit 4 = 1 (post) gives `ea` = the unmodified base. Bit 4 = 0 (pre) gives `ea` = `wb_val`.
- R5: If bits 7:5 are 111, bits 4:3 pick the base (same coding as R2). Bits 2:0 of 000 or 001 give `ea` = base + {bit 0 as sign, `ext0`}, a 9-bit signed offset, with `len` = 2.
- R6: A 111 group with bits 2:0 = 010 gives `ea` = base + {`ext0`,`ext1`}, where `ext0` is the high byte, with `len` = 3 and `indirect` = 0.
- R7: A 111 group with bits 2:0 = 011 gives `ea` = base + {`ext0`,`ext1`}, `len` = 3 and `indirect` = 1. Bits 2:0 = 111 give `ea` = base + D, `len` = 1 and `indirect` = 1. No other form sets `indirect`.
- R8: A 111 group with bits 2:0 of 100, 101 or 110 adds A, B or D to the base, with `len` = 1. A and B are zero-extended. D is {A, B}.
- R9: A PC base equals `pc_here` + `len`, where `pc_here` is the address of the postbyte.
- R10: `illegal` = 1 only when `mov_ctx` = 1 and the postbyte is in the 111 group with bit 2 = 0 (9-bit, 16-bit or 16-bit indirect). All address outputs are still produced in that case.
- R11: All address sums wrap modulo 2^16. In modes other than auto-modify, `wb_en`, `wb_sel` and `wb_val` are 0.
- R12: While `rst_n` is low, `valid` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the inputs and compute |
| postbyte | input | 8 | Indexed addressing byte |
| ext0 | input | 8 | First byte after the postbyte |
| ext1 | input | 8 | Second byte after the postbyte |
| mov_ctx | input | 1 | Postbyte belongs to a memory-to-memory move |
| pc_here | input | 16 | Address of the postbyte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| valid | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address (pointer address when indirect) |
| len | output | 2 | Bytes used by the postbyte and its extension |
| indirect | output | 1 | Address must be dereferenced |
| wb_en | output | 1 | Base register writeback enable |
| wb_sel | output | 2 | Register to write back (00 X, 01 Y, 10 SP) |
| wb_val | output | 16 | Modified base register value |
| illegal | output | 1 | Form not allowed in a move |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the valid pulse follows `start` by exactly one cycle;
- writeback appears only with 1-byte, non-indirect, non-PC results;
- a post-modify address always differs from the written-back value, and a pre-modify address always equals it;
- `illegal` and `indirect` occur only with the postbyte groups that allow them.

The bench scenarios cover what depends on the data:
- the exact sum for each offset width and sign;
- the PC base moving with the length;
- zero-extension of A and B against a full-width D;
- wrap-around at both ends of the address space;
- outputs that hold when no `start` arrives.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    MODE_K5,
    MODE_AUTO,
    MODE_K9,
    MODE_K16,
    MODE_K16_IND,
    MODE_ACC_A,
    MODE_ACC_B,
    MODE_ACC_D,
    MODE_ACC_D_IND
  } idx_mode_e;

  typedef struct packed {
    idx_mode_e  mode;
    logic [1:0] base_sel;
    logic [1:0] len;
    logic       post;
    logic       indir;
    logic       move_bad;
  } idx_dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_agen_pkg::*;
(
  input  logic [7:0] pb,
  output idx_dec_t   dec
);
  always_comb begin
    dec          = '0;
    dec.mode     = MODE_K5;
    dec.base_sel = pb[7:6];
    dec.len      = 2'd1;
    if (!pb[5]) begin
      dec.mode = MODE_K5;
    end else if (pb[7:6] != 2'b11) begin
      dec.mode = MODE_AUTO;
      dec.post = pb[4];
    end else begin
      dec.base_sel = pb[4:3];
      unique case (pb[2:0])
        3'b000, 3'b001: begin
          dec.mode = MODE_K9;  dec.len = 2'd2; dec.move_bad = 1'b1;
        end
        3'b010: begin
          dec.mode = MODE_K16; dec.len = 2'd3; dec.move_bad = 1'b1;
        end
        3'b011: begin
          dec.mode = MODE_K16_IND; dec.len = 2'd3;
          dec.indir = 1'b1; dec.move_bad = 1'b1;
        end
        3'b100: dec.mode = MODE_ACC_A;
        3'b101: dec.mode = MODE_ACC_B;
        3'b110: dec.mode = MODE_ACC_D;
        default: begin
          dec.mode = MODE_ACC_D_IND; dec.indir = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/idx_calc.sv
module idx_calc
  import idx_agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  idx_mode_e     mode,
  input  logic [1:0]    base_sel,
  input  logic [1:0]    len,
  input  logic          post,
  input  logic [4:0]    pb_lo,
  input  logic [BW-1:0] ext0,
  input  logic [BW-1:0] ext1,
  input  logic [AW-1:0] pc_here,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic [AW-1:0] base_val,
  output logic [AW-1:0] offset,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);
  function automatic logic [AW-1:0] k5_off(input logic [4:0] f);
    return {{(AW-5){f[4]}}, f};
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [3:0] n);
    if (n[3]) return {{(AW-4){1'b1}}, n};
    return {{(AW-4){1'b0}}, n} + AW'(1);
  endfunction

  function automatic logic [AW-1:0] zext(input logic [BW-1:0] b);
    return {{(AW-BW){1'b0}}, b};
  endfunction

  logic [AW-1:0] sum;

  always_comb begin
    unique case (base_sel)
      2'b00:   base_val = reg_x;
      2'b01:   base_val = reg_y;
      2'b10:   base_val = reg_sp;
      default: base_val = pc_here + AW'(len);
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_K5:                offset = k5_off(pb_lo);
      MODE_AUTO:              offset = step_of(pb_lo[3:0]);
      MODE_K9:                offset = {{(AW-BW){pb_lo[0]}}, ext0};
      MODE_K16, MODE_K16_IND: offset = {ext0, ext1};
      MODE_ACC_A:             offset = zext(acc_a);
      MODE_ACC_B:             offset = zext(acc_b);
      default:                offset = {acc_a, acc_b};
    endcase
  end

  assign sum = base_val + offset;

  always_comb begin
    if (mode == MODE_AUTO) begin
      wb_en  = 1'b1;
      wb_val = sum;
      ea     = post ? base_val : sum;
    end else begin
      wb_en  = 1'b0;
      wb_val = '0;
      ea     = sum;
    end
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    postbyte,
  input  logic [BW-1:0] ext0,
  input  logic [BW-1:0] ext1,
  input  logic          mov_ctx,
  input  logic [AW-1:0] pc_here,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic          valid,
  output logic [AW-1:0] ea,
  output logic [1:0]    len,
  output logic          indirect,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          illegal
);
  idx_dec_t      dec;
  logic [AW-1:0] base_val;
  logic [AW-1:0] offset;
  logic [AW-1:0] ea_nx;
  logic [AW-1:0] wb_val_nx;
  logic          wb_en_nx;
  logic          illegal_nx;

  idx_decode u_dec (
    .pb  (postbyte),
    .dec (dec)
  );

  idx_calc #(.AW(AW), .BW(BW)) u_calc (
    .mode     (dec.mode),
    .base_sel (dec.base_sel),
    .len      (dec.len),
    .post     (dec.post),
    .pb_lo    (postbyte[4:0]),
    .ext0     (ext0),
    .ext1     (ext1),
    .pc_here  (pc_here),
    .reg_x    (reg_x),
    .reg_y    (reg_y),
    .reg_sp   (reg_sp),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .base_val (base_val),
    .offset   (offset),
    .ea       (ea_nx),
    .wb_en    (wb_en_nx),
    .wb_val   (wb_val_nx)
  );

  assign illegal_nx = mov_ctx & dec.move_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      ea       <= '0;
      len      <= '0;
      indirect <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
      illegal  <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        ea       <= ea_nx;
        len      <= dec.len;
        indirect <= dec.indir;
        wb_en    <= wb_en_nx;
        wb_sel   <= wb_en_nx ? dec.base_sel : 2'b00;
        wb_val   <= wb_val_nx;
        illegal  <= illegal_nx;
      end
    end
  end
endmodule

// File: rtl/idx_agen_chk.sv
module idx_agen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mov_ctx,
  input logic [2:0]    pb_grp,
  input logic          pb_post,
  input logic [1:0]    pb_low2,
  input logic          valid,
  input logic [AW-1:0] ea,
  input logic [1:0]    len,
  input logic          indirect,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic [AW-1:0] wb_val,
  input logic          illegal
);
  AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid); // R1
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (len != 2'd0)); // R5
  AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (len == 2'd1 && !indirect && !illegal && wb_sel != 2'b11)); // R3
  AST_POST_USES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wb_en && $past(pb_post)) |-> (ea != wb_val)); // R4
  AST_PRE_USES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wb_en && !$past(pb_post)) |-> (ea == wb_val)); // R4
  AST_ILLEGAL_ONLY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && illegal) |-> ($past(mov_ctx) && $past(pb_grp) == 3'b111)); // R10
  AST_INDIRECT_FORMS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && indirect) |-> ($past(pb_grp) == 3'b111 && $past(pb_low2) == 2'b11)); // R7
  AST_WB_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en |-> (wb_val == '0 && wb_sel == 2'b00)); // R11
endmodule

bind idx_agen idx_agen_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mov_ctx  (mov_ctx),
  .pb_grp   (postbyte[7:5]),
  .pb_post  (postbyte[4]),
  .pb_low2  (postbyte[1:0]),
  .valid    (valid),
  .ea       (ea),
  .len      (len),
  .indirect (indirect),
  .wb_en    (wb_en),
  .wb_sel   (wb_sel),
  .wb_val   (wb_val),
  .illegal  (illegal)
);

// File: tb/idx_agen_tb.sv
module idx_agen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0, ext0 = '0, ext1 = '0;
  logic        mov_ctx = 1'b0;
  logic [15:0] pc_here = 16'h8000, reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3FF0;
  logic [7:0]  acc_a = 8'hF0, acc_b = 8'h0F;
  logic        valid, indirect, wb_en, illegal;
  logic [15:0] ea, wb_val;
  logic [1:0]  len, wb_sel;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idx_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte), .ext0(ext0),
    .ext1(ext1), .mov_ctx(mov_ctx), .pc_here(pc_here), .reg_x(reg_x),
    .reg_y(reg_y), .reg_sp(reg_sp), .acc_a(acc_a), .acc_b(acc_b),
    .valid(valid), .ea(ea), .len(len), .indirect(indirect), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val), .illegal(illegal)
  );

  // {pb, ext0, ext1, mov, ea, len, ind, wbe, wbsel, wbval, ill}
  // Registers: X=1000 Y=2000 SP=3FF0 PC(postbyte)=8000 A=F0 B=0F
  localparam int NV = 23;
  localparam logic [63:0] VEC [NV] = '{
    {8'h05,8'hAA,8'h55,1'b0,16'h1005,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R2 X+5
    {8'h5F,8'hAA,8'h55,1'b0,16'h1FFF,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R2 Y-1
    {8'hD0,8'hAA,8'h55,1'b0,16'h7FF1,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R2 R9 PC-16
    {8'h93,8'hAA,8'h55,1'b0,16'h3FE3,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R2 SP-13
    {8'h23,8'hAA,8'h55,1'b0,16'h1004,2'd1,1'b0,1'b1,2'd0,16'h1004,1'b0}, // R3 R4 pre +4
    {8'h7C,8'hAA,8'h55,1'b0,16'h2000,2'd1,1'b0,1'b1,2'd1,16'h1FFC,1'b0}, // R3 R4 post -4
    {8'hA8,8'hAA,8'h55,1'b0,16'h3FE8,2'd1,1'b0,1'b1,2'd2,16'h3FE8,1'b0}, // R3 pre -8
    {8'h37,8'hAA,8'h55,1'b0,16'h1000,2'd1,1'b0,1'b1,2'd0,16'h1008,1'b0}, // R3 post +8
    {8'hE1,8'h80,8'h55,1'b0,16'h0F80,2'd2,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R5 -128
    {8'hE8,8'hFF,8'h55,1'b0,16'h20FF,2'd2,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R5 +255
    {8'hF9,8'hFE,8'h55,1'b0,16'h8000,2'd2,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R5 R9 PC+2-2
    {8'hF2,8'hC0,8'h20,1'b0,16'h0010,2'd3,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R6 R11 wrap
    {8'hE3,8'h12,8'h34,1'b0,16'h2234,2'd3,1'b1,1'b0,2'd0,16'h0000,1'b0}, // R7
    {8'hFB,8'hFF,8'hFD,1'b0,16'h8000,2'd3,1'b1,1'b0,2'd0,16'h0000,1'b0}, // R7 R9
    {8'hEC,8'hAA,8'h55,1'b0,16'h20F0,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R8 A zext
    {8'hE5,8'hAA,8'h55,1'b0,16'h100F,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R8 B
    {8'hF6,8'hAA,8'h55,1'b0,16'h2FFF,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R8 D wrap
    {8'hFF,8'hAA,8'h55,1'b0,16'h7010,2'd1,1'b1,1'b0,2'd0,16'h0000,1'b0}, // R7 R9 [D,PC]
    {8'hE3,8'h12,8'h34,1'b1,16'h2234,2'd3,1'b1,1'b0,2'd0,16'h0000,1'b1}, // R10
    {8'hE1,8'h80,8'h55,1'b1,16'h0F80,2'd2,1'b0,1'b0,2'd0,16'h0000,1'b1}, // R10
    {8'h05,8'hAA,8'h55,1'b1,16'h1005,2'd1,1'b0,1'b0,2'd0,16'h0000,1'b0}, // R10 legal
    {8'hE7,8'hAA,8'h55,1'b1,16'h000F,2'd1,1'b1,1'b0,2'd0,16'h0000,1'b0}, // R10 [D,X]
    {8'h37,8'hAA,8'h55,1'b1,16'h1000,2'd1,1'b0,1'b1,2'd0,16'h1008,1'b0}  // R10 auto ok
  };

  function automatic string tag_of(input logic [7:0] pb, input logic mv);
    if (mv) return "R10";
    if (!pb[5]) return "R2";
    if (pb[7:6] != 2'b11) return "R3";
    case (pb[2:0])
      3'b000, 3'b001: return "R5";
      3'b010: return "R6";
      3'b011, 3'b111: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] pb, input logic [7:0] e0, input logic [7:0] e1, input logic mv);
    @(negedge clk);
    postbyte = pb; ext0 = e0; ext1 = e1; mov_ctx = mv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12", "valid", 16'(valid), 16'h0);
    cmp("R12", "ea", ea, 16'h0000);
    cmp("R12", "wb_en", 16'(wb_en), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[63:56], v[39]);
      issue(v[63:56], v[55:48], v[47:40], v[39]);
      cmp("R1", "valid", 16'(valid), 16'h1);
      cmp(t, "ea", ea, v[38:23]);
      cmp(t, "len", 16'(len), 16'(v[22:21]));
      cmp(t, "indirect", 16'(indirect), 16'(v[20]));
      cmp(t, "wb_en", 16'(wb_en), 16'(v[19]));
      cmp(t, "wb_sel", 16'(wb_sel), 16'(v[18:17]));
      cmp(t, "wb_val", wb_val, v[16:1]);
      cmp(t, "illegal", 16'(illegal), 16'(v[0]));
    end

    // R1: inputs change without start; outputs hold, valid low
    @(negedge clk);
    postbyte = 8'h05; mov_ctx = 1'b0;
    @(negedge clk);
    cmp("R1", "valid idle", 16'(valid), 16'h0);
    cmp("R1", "ea hold", ea, 16'h1000);
    cmp("R1", "wb_val hold", wb_val, 16'h1008);

    // R11: wrap at top of address space, 5-bit offset
    reg_x = 16'hFFFE;
    issue(8'h02, 8'h00, 8'h00, 1'b0);
    cmp("R11", "ea wrap k5", ea, 16'h0000);
    cmp("R11", "wb_en off", 16'(wb_en), 16'h0);
    // R11 R4: pre-increment by 1 across FFFF
    reg_x = 16'hFFFF;
    issue(8'h20, 8'h00, 8'h00, 1'b0);
    cmp("R11", "ea pre wrap", ea, 16'h0000);
    cmp("R11", "wb_val wrap", wb_val, 16'h0000);
    // R3: decrement by 1 from zero
    reg_y = 16'h0000;
    issue(8'h7F, 8'h00, 8'h00, 1'b0);
    cmp("R3", "ea post", ea, 16'h0000);
    cmp("R3", "wb_val -1", wb_val, 16'hFFFF);
    cmp("R3", "wb_sel Y", 16'(wb_sel), 16'h1);

    // R12: reset in the middle clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    cmp("R12", "valid rst", 16'(valid), 16'h0);
    cmp("R12", "wb_val rst", wb_val, 16'h0000);
    cmp("R12", "ea rst", ea, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule